// File: doc/BRIEF.md
# Host Command Port for a Power-Management Companion

This block is the serial command port through which a host microcontroller talks to a power-management companion device. The host drives chip select low and clocks one 16-bit word on MOSI, MSB first. The block answers on MISO in the same frame. During the first eight clocks it shifts out zeros. Once the first byte (the opcode) has arrived, it shifts out an eight-bit status byte chosen by that opcode.

When chip select rises after exactly sixteen clocks, the word is acted on:
- a watchdog refresh becomes a one-cycle pulse;
- a configuration write becomes a one-cycle strobe for one of four initialisation registers, but only while the mode controller reports INIT;
- a complete regulator-flag read clears the sticky battery-fail flag.

While the mode controller reports the low-power state that keeps the host supplied, every chip-select edge produces a wake pulse. All port pins are brought into the system clock domain through synchronizers. SCLK must therefore be much slower than the system clock.

Top module: `cfg_spi_port`

## Requirements
- R1: MOSI is captured MSB first on rising SCLK while chip select is low. A frame is acted on only when chip select rises after exactly 16 rising SCLK edges; frames with any other count cause no pulse, no strobe and no flag change.
- R2: The word 0x5A00 produces exactly one single-cycle `wdog_refresh_o` pulse after chip select rises. Any other word, such as 0x5A01, produces none.
- R3: MISO changes only on falling SCLK edges and chip-select edges (SPI mode 0). Response bits 15..8 are zero. When the opcode byte (bits 15..8 of the word) is 0xDD, response bits 7..3 carry `mode_i[4:0]` and bits 2..0 are zero. Mode codes are: 00000 INIT, 00001 FLASH, 00010 NORMAL REQUEST, 00011 NORMAL, 1xxxx low power.
- R4: When the opcode byte is 0xDF, response bits 7..2 and bit 0 are taken from `vreg_flags_i` at the same positions. Bit 1 is the sticky battery-fail flag, which reset sets to 1, whatever `vreg_flags_i[1]` is.
- R5: A complete frame of 0xDF00 or 0xDF80 clears the battery-fail flag after the frame. The frame itself still returns the old value. A 0xDF frame with any other low byte, or with a wrong bit count, leaves the flag set.
- R6: A word with opcode 0x60+k (k = 0 watchdog setup, 1 regulator, 2 I/O, 3 misc) and data byte D pulses `cfg_wr_strobe_o[k]` for one cycle with `cfg_wr_data_o` = D, but only if `mode_i` is 00000. In any other mode no strobe bit rises.
- R7: `spi_miso_oe` is high only while the synchronized chip select is low. Whenever `spi_miso_oe` is low, `spi_miso` is 0.
- R8: While `lp_vdd_on_i` is high, each falling and each rising chip-select edge produces one single-cycle `wake_o` pulse. While it is low, no wake pulse occurs.
- R9: Any other opcode returns an all-zero response and produces no refresh and no strobe.
- R10: After reset all pulse and strobe outputs are 0, `spi_miso_oe` is 0 and `spi_miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Drive enable for the MISO pad; low means high-impedance |
| mode_i | input | 5 | Current operating mode from the mode controller |
| lp_vdd_on_i | input | 1 | High while in the low-power state that keeps the host supplied |
| vreg_flags_i | input | 8 | Live regulator flags; bit 1 is replaced by the sticky flag |
| wdog_refresh_o | output | 1 | One-cycle watchdog refresh pulse |
| cfg_wr_strobe_o | output | 4 | One-hot write strobe for the init registers |
| cfg_wr_data_o | output | 8 | Data byte for the strobed register |
| wake_o | output | 1 | One-cycle wake event on a chip-select edge |

## Verification
The mode read is swept over all 32 mode codes. This separates correct placement in bits 7..3 from shifted or truncated fields. The regulator read is swept over a spread of flag patterns, before and after the sticky bit is cleared, which shows whether bit 1 is substituted while its neighbours pass through. Every write opcode is tried in every mode, which shows the strobe index, the data byte and the INIT-only lock. Refresh and read words are also sent with 15 and 17 clocks and with near-miss low bytes; these tell a full-word decode from one that looks only at the opcode or accepts any frame length.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

    localparam int FRAME_W = 16;
    localparam int BYTE_W  = FRAME_W / 2;
    localparam int MODE_W  = 5;
    localparam int NUM_CFG = 4;
    localparam int IDX_W   = $clog2(NUM_CFG);

    localparam logic [BYTE_W-1:0] OP_REFRESH = 8'h5A;
    localparam logic [BYTE_W-1:0] OP_RD_MODE = 8'hDD;
    localparam logic [BYTE_W-1:0] OP_RD_VREG = 8'hDF;
    localparam logic [BYTE_W-1:0] OP_WR_BASE = 8'h60;
    localparam logic [BYTE_W-1:0] ARG_ZERO   = 8'h00;
    localparam logic [BYTE_W-1:0] ARG_HIGH   = 8'h80;
    localparam logic [MODE_W-1:0] MODE_INIT  = '0;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_REFRESH,
        CMD_RD_MODE,
        CMD_RD_VREG,
        CMD_RD_VREG_CLR,
        CMD_WRITE
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e         kind;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] arg;
    } cmd_t;

    // Classify a complete frame word.
    function automatic cmd_t decode_word(input logic [FRAME_W-1:0] w);
        cmd_t c;
        logic [BYTE_W-1:0] op;
        logic [BYTE_W-1:0] arg;
        op     = w[FRAME_W-1 -: BYTE_W];
        arg    = w[BYTE_W-1:0];
        c.kind = CMD_NONE;
        c.idx  = op[IDX_W-1:0];
        c.arg  = arg;
        if (op == OP_REFRESH && arg == ARG_ZERO) begin
            c.kind = CMD_REFRESH;
        end else if (op == OP_RD_MODE) begin
            c.kind = CMD_RD_MODE;
        end else if (op == OP_RD_VREG) begin
            c.kind = (arg == ARG_ZERO || arg == ARG_HIGH) ? CMD_RD_VREG_CLR : CMD_RD_VREG;
        end else if (op[BYTE_W-1:IDX_W] == OP_WR_BASE[BYTE_W-1:IDX_W]) begin
            c.kind = CMD_WRITE;
        end
        return c;
    endfunction

endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= RST_VAL;
            else     chain[s] <= chain[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

endmodule

// File: rtl/cfg_spi_frame.sv
module cfg_spi_frame
    import cfg_spi_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sclk_rise,
    input  logic            sclk_fall,
    input  logic            cs_lvl,
    input  logic            cs_fall,
    input  logic            cs_rise,
    input  logic            mosi_lvl,
    input  logic [FW/2-1:0] resp_byte,
    output logic [FW-1:0]   rx_word,
    output logic            frame_ok,
    output logic            miso,
    output logic            miso_oe
);

    localparam int HALF  = FW / 2;
    localparam int CNT_W = $clog2(FW + 2);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FW + 1);

    logic [FW-1:0]   sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic [HALF-1:0] tx_q;
    logic            miso_q;
    logic            oe_q;
    logic            ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            tx_q   <= '0;
            miso_q <= 1'b0;
            oe_q   <= 1'b0;
            ok_q   <= 1'b0;
        end else begin
            ok_q <= 1'b0;
            if (cs_fall) begin
                cnt_q  <= '0;
                tx_q   <= '0;
                miso_q <= 1'b0;
                oe_q   <= 1'b1;
            end else if (cs_rise) begin
                ok_q   <= (cnt_q == CNT_FULL);
                miso_q <= 1'b0;
                oe_q   <= 1'b0;
            end else if (!cs_lvl) begin
                if (sclk_rise) begin
                    sh_q <= {sh_q[FW-2:0], mosi_lvl};
                    if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
                end else if (sclk_fall) begin
                    if (cnt_q == CNT_HALF) begin
                        miso_q <= resp_byte[HALF-1];
                        tx_q   <= {resp_byte[HALF-2:0], 1'b0};
                    end else if (cnt_q > CNT_HALF) begin
                        miso_q <= tx_q[HALF-1];
                        tx_q   <= {tx_q[HALF-2:0], 1'b0};
                    end else begin
                        miso_q <= 1'b0;
                    end
                end
            end
        end
    end

    assign rx_word  = sh_q;
    assign frame_ok = ok_q;
    assign miso     = miso_q;
    assign miso_oe  = oe_q;

    // R7: the pad is never driven with data while released
    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !oe_q |-> !miso_q);

    // R3: data only moves on a falling clock or a select edge
    a_r3_mode0_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(sclk_fall) && !$past(cs_fall) && !$past(cs_rise)) |-> $stable(miso_q));

    // R1: a frame is only accepted right after select is released
    a_r1_ok_after_rise: assert property (@(posedge clk) disable iff (rst)
        ok_q |-> $past(cs_rise));

    // R1: bit counter saturates
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_OVER);

endmodule

// File: rtl/cfg_spi_cmd.sv
module cfg_spi_cmd
    import cfg_spi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [FRAME_W-1:0] rx_word,
    input  logic               frame_ok,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic [BYTE_W-1:0]  vreg_flags_i,
    output logic [BYTE_W-1:0]  resp_byte,
    output logic               refresh_o,
    output logic [NUM_CFG-1:0] wr_strobe_o,
    output logic [BYTE_W-1:0]  wr_data_o
);

    localparam int PAD_W = BYTE_W - MODE_W;

    logic              batfail_q;
    logic              refresh_q;
    logic [NUM_CFG-1:0] strobe_q;
    logic [BYTE_W-1:0] data_q;
    cmd_t              cmd;

    // The opcode sits in the low byte of the shifter halfway through the frame.
    always_comb begin
        unique case (rx_word[BYTE_W-1:0])
            OP_RD_MODE: resp_byte = {mode_i, {PAD_W{1'b0}}};
            OP_RD_VREG: resp_byte = {vreg_flags_i[BYTE_W-1:2], batfail_q, vreg_flags_i[0]};
            default:    resp_byte = '0;
        endcase
    end

    assign cmd = decode_word(rx_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            batfail_q <= 1'b1;
            refresh_q <= 1'b0;
            strobe_q  <= '0;
            data_q    <= '0;
        end else begin
            refresh_q <= 1'b0;
            strobe_q  <= '0;
            if (frame_ok) begin
                unique case (cmd.kind)
                    CMD_REFRESH:     refresh_q <= 1'b1;
                    CMD_RD_VREG_CLR: batfail_q <= 1'b0;
                    CMD_WRITE: begin
                        if (mode_i == MODE_INIT) begin
                            for (int k = 0; k < NUM_CFG; k++) begin
                                strobe_q[k] <= (cmd.idx == IDX_W'(k));
                            end
                            data_q <= cmd.arg;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign refresh_o   = refresh_q;
    assign wr_strobe_o = strobe_q;
    assign wr_data_o   = data_q;

    // R6: at most one register is written at a time
    a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_q));

    // R6: writes only land while the mode controller reports INIT
    a_r6_init_lock: assert property (@(posedge clk) disable iff (rst)
        (|strobe_q) |-> ($past(mode_i) == MODE_INIT));

    // R2: refresh is a single-cycle pulse
    a_r2_refresh_pulse: assert property (@(posedge clk) disable iff (rst)
        refresh_q |=> !refresh_q);

    // R5: the sticky flag is only ever set by reset
    a_r5_sticky_no_set: assert property (@(posedge clk) disable iff (rst)
        !$rose(batfail_q));

endmodule

// File: rtl/cfg_spi_port.sv
module cfg_spi_port
    import cfg_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               spi_sclk,
    input  logic               spi_cs_n,
    input  logic               spi_mosi,
    output logic               spi_miso,
    output logic               spi_miso_oe,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic               lp_vdd_on_i,
    input  logic [BYTE_W-1:0]  vreg_flags_i,
    output logic               wdog_refresh_o,
    output logic [NUM_CFG-1:0] cfg_wr_strobe_o,
    output logic [BYTE_W-1:0]  cfg_wr_data_o,
    output logic               wake_o
);

    localparam int PIN_CS   = 2;
    localparam int PIN_SCLK = 1;
    localparam int PIN_MOSI = 0;
    localparam logic [2:0] PIN_IDLE = 3'b100;

    logic [2:0] pin_lvl, pin_rise, pin_fall;
    logic [FRAME_W-1:0] rx_word;
    logic [BYTE_W-1:0]  resp_byte;
    logic               frame_ok;
    logic               wake_q;

    cfg_spi_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({spi_cs_n, spi_sclk, spi_mosi}),
        .lvl  (pin_lvl),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    cfg_spi_frame #(
        .FW (FRAME_W)
    ) u_frame (
        .clk       (clk),
        .rst       (rst),
        .sclk_rise (pin_rise[PIN_SCLK]),
        .sclk_fall (pin_fall[PIN_SCLK]),
        .cs_lvl    (pin_lvl[PIN_CS]),
        .cs_fall   (pin_fall[PIN_CS]),
        .cs_rise   (pin_rise[PIN_CS]),
        .mosi_lvl  (pin_lvl[PIN_MOSI]),
        .resp_byte (resp_byte),
        .rx_word   (rx_word),
        .frame_ok  (frame_ok),
        .miso      (spi_miso),
        .miso_oe   (spi_miso_oe)
    );

    cfg_spi_cmd u_cmd (
        .clk          (clk),
        .rst          (rst),
        .rx_word      (rx_word),
        .frame_ok     (frame_ok),
        .mode_i       (mode_i),
        .vreg_flags_i (vreg_flags_i),
        .resp_byte    (resp_byte),
        .refresh_o    (wdog_refresh_o),
        .wr_strobe_o  (cfg_wr_strobe_o),
        .wr_data_o    (cfg_wr_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) wake_q <= 1'b0;
        else     wake_q <= lp_vdd_on_i & (pin_rise[PIN_CS] | pin_fall[PIN_CS]);
    end

    assign wake_o = wake_q;

    // R8: wake is only reported while the supplied low-power state is active
    a_r8_wake_gated: assert property (@(posedge clk) disable iff (rst)
        wake_q |-> $past(lp_vdd_on_i));

    // R8: one pulse per edge
    a_r8_wake_pulse: assert property (@(posedge clk) disable iff (rst)
        wake_q |=> !wake_q);

endmodule

// File: tb/cfg_spi_port_bench.sv
module cfg_spi_port_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso, miso_oe;
    logic [4:0] mode = 5'b0;
    logic       lp_on = 1'b0;
    logic [7:0] vflags = 8'h00;
    logic       refresh;
    logic [3:0] strobe;
    logic [7:0] wdata;
    logic       wake;

    int n_cmp = 0;
    int n_bad = 0;
    int n_ref = 0;
    int n_wr = 0;
    int n_wake = 0;
    logic [3:0] last_strb = '0;
    logic [7:0] last_data = '0;

    always #5 clk = ~clk;

    cfg_spi_port u_cfg_spi_port (
        .clk             (clk),
        .rst             (rst),
        .spi_sclk        (sclk),
        .spi_cs_n        (cs_n),
        .spi_mosi        (mosi),
        .spi_miso        (miso),
        .spi_miso_oe     (miso_oe),
        .mode_i          (mode),
        .lp_vdd_on_i     (lp_on),
        .vreg_flags_i    (vflags),
        .wdog_refresh_o  (refresh),
        .cfg_wr_strobe_o (strobe),
        .cfg_wr_data_o   (wdata),
        .wake_o          (wake)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (refresh) n_ref++;
            if (wake) n_wake++;
            if (|strobe) begin
                n_wr++;
                last_strb = strobe;
                last_data = wdata;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One transfer of nbits clocks; returns the bits seen on MISO before each rising edge.
    task automatic xfer(input logic [15:0] w, input int nbits,
                        output logic [15:0] rx, output logic oe_all);
        rx = '0;
        oe_all = 1'b1;
        cs_n = 1'b0;
        ticks(8);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? w[15-i] : 1'b0;
            ticks(8);
            if (i < 16) rx[15-i] = miso;
            oe_all = oe_all & miso_oe;
            sclk = 1'b1;
            ticks(8);
            sclk = 1'b0;
        end
        ticks(8);
        cs_n = 1'b1;
        ticks(10);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ticks(4);
        rst = 1'b0;
        ticks(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] rx;
        logic        oe;
        int          r0;
        int          w0;
        int          k0;

        ticks(3);
        do_reset();
        // R10: reset state
        check("R10 miso_oe", miso_oe, 0);
        check("R10 miso", miso, 0);
        check("R10 outputs", {refresh, strobe, wake}, 0);

        // R5: short frame of a clearing read leaves flag set; odd arg keeps it
        vflags = 8'h00;
        xfer(16'hDF80, 15, rx, oe);
        xfer(16'hDF01, 16, rx, oe);
        check("R4 sticky after reset", rx, 16'h0002);
        xfer(16'hDF01, 16, rx, oe);
        check("R5 odd arg keeps flag", rx, 16'h0002);
        xfer(16'hDF80, 16, rx, oe);
        check("R5 clearing read returns old", rx, 16'h0002);
        xfer(16'hDF01, 16, rx, oe);
        check("R5 cleared by DF80", rx, 16'h0000);
        check("R7 oe during frame", oe, 1);
        check("R7 oe after frame", {miso_oe, miso}, 0);

        // R4: flag sweep with sticky bit clear, bit 1 of input must not leak
        for (int i = 0; i < 52; i++) begin
            logic [7:0] v;
            v = 8'(i * 5);
            vflags = v;
            xfer(16'hDF00, 16, rx, oe);
            check("R4 vreg sweep", rx, {8'h00, v[7:2], 1'b0, v[0]});
        end

        // R5: fresh power-up, DF00 clears too
        do_reset();
        vflags = 8'hFD;
        xfer(16'hDF00, 16, rx, oe);
        check("R4 bit1 from flag", rx, 16'h00FF);
        xfer(16'hDF00, 16, rx, oe);
        check("R5 cleared by DF00", rx, 16'h00FD);

        // R3: mode read, all codes
        for (int m = 0; m < 32; m++) begin
            mode = 5'(m);
            xfer(16'hDD80, 16, rx, oe);
            check("R3 mode read", rx, {8'h00, 5'(m), 3'b000});
        end
        mode = 5'b0;

        // R2 / R1: refresh, including bad counts and near-miss arg
        r0 = n_ref;
        xfer(16'h5A00, 16, rx, oe);
        check("R2 refresh once", n_ref - r0, 1);
        check("R9 refresh resp zero", rx, 0);
        r0 = n_ref;
        xfer(16'h5A00, 15, rx, oe);
        check("R1 15 clocks ignored", n_ref - r0, 0);
        xfer(16'h5A00, 17, rx, oe);
        check("R1 17 clocks ignored", n_ref - r0, 0);
        xfer(16'h5A01, 16, rx, oe);
        check("R2 5A01 no refresh", n_ref - r0, 0);

        // R9: unknown opcode
        w0 = n_wr;
        r0 = n_ref;
        xfer(16'h1234, 16, rx, oe);
        check("R9 unknown resp", rx, 0);
        check("R9 unknown no action", (n_wr - w0) + (n_ref - r0), 0);

        // R1: short write frame is dropped
        w0 = n_wr;
        xfer(16'h61AA, 12, rx, oe);
        check("R1 short write dropped", n_wr - w0, 0);

        // R6: every write opcode in every mode
        for (int m = 0; m < 32; m++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] d;
                d = 8'((m * 8 + k) ^ 8'hA5);
                mode = 5'(m);
                w0 = n_wr;
                xfer({8'h60 + 8'(k), d}, 16, rx, oe);
                if (m == 0) begin
                    check("R6 write strobe", n_wr - w0, 1);
                    check("R6 strobe index", last_strb, 4'b0001 << k);
                    check("R6 write data", last_data, d);
                end else begin
                    check("R6 locked outside INIT", n_wr - w0, 0);
                end
            end
        end
        mode = 5'b0;

        // R8: wake on select edges
        k0 = n_wake;
        xfer(16'h1234, 16, rx, oe);
        check("R8 no wake when off", n_wake - k0, 0);
        lp_on = 1'b1;
        mode = 5'b10000;
        k0 = n_wake;
        xfer(16'hDD80, 16, rx, oe);
        check("R8 wake per edge", n_wake - k0, 2);
        check("R3 low-power code", rx, 16'h0080);
        k0 = n_wake;
        xfer(16'h0000, 3, rx, oe);
        check("R8 wake on short frame", n_wake - k0, 2);
        lp_on = 1'b0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule